// File: doc/BRIEF.md
# Keyboard and Display Device Register Block

This block holds the device registers that sit between a processor's load/store path and two character devices: a keyboard that offers one character at a time, and a character display that shows one character at a time. An external address decoder turns the processor's accesses into one read or write strobe per register. The block returns the read data in the same cycle as the read strobe and raises one interrupt request line.

Each channel has a status word. The top bit of the status word is a ready flag and the bit below it is an interrupt enable. The ready flags are driven by the device handshakes and by side effects of data register accesses, never by a direct store. Reading the keyboard character releases the keyboard so it can offer the next one. Writing a display character marks the display busy until the display reports that it has shown it. The interrupt line is high whenever a channel has both its ready flag and its enable set.

Top module: `kd_regs`

## Requirements
- R1: After reset the keyboard status reads 0x0000, the display status reads 0x8000, `kb_ready_o` is 1, `dp_valid_o` is 0 and `irq_o` is 0.
- R2: A character offered with `kb_valid_i` while `kb_ready_o` is 1 is latched at that clock edge. From the next cycle the keyboard status bit 15 reads 1 and `kb_ready_o` is 0.
- R3: While the keyboard ready flag is set, `kb_ready_o` is 0 and offered characters are refused: the held character does not change.
- R4: A read of the keyboard data register returns the held character in bits 7:0 and clears the keyboard ready flag at that clock edge, so `kb_ready_o` is 1 in the next cycle.
- R5: A character offered in the same cycle as a keyboard data read, while the flag is set, is not taken in that cycle. It is taken in the following cycle if still offered.
- R6: A write of the display data register latches bits 7:0 onto `dp_char_o`, raises `dp_valid_o` and clears display status bit 15 from the next cycle.
- R7: A `dp_done_i` pulse while the display is busy sets display status bit 15 and drops `dp_valid_o` from the next cycle. A pulse while the display is ready has no effect.
- R8: A write to either status register changes only bit 14 (the interrupt enable), taken from write data bit 14. Bit 15 keeps its value.
- R9: `irq_o` is 1 exactly when bits 15 and 14 are both set in the keyboard status or both set in the display status.
- R10: Keyboard data bits 15:8 and status bits 13:0 read as zero, and `rd_data_o` is zero when no read strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kb_char_i | input | 8 | Character offered by the keyboard |
| kb_valid_i | input | 1 | Keyboard offers a character |
| kb_ready_o | output | 1 | Block can take a keyboard character |
| dp_char_o | output | 8 | Character presented to the display |
| dp_valid_o | output | 1 | Display character pending |
| dp_done_i | input | 1 | Display has finished showing the character |
| wr_data_i | input | 16 | CPU write data |
| ksts_rd_i | input | 1 | Read keyboard status |
| ksts_wr_i | input | 1 | Write keyboard status |
| kdat_rd_i | input | 1 | Read keyboard data |
| dsts_rd_i | input | 1 | Read display status |
| dsts_wr_i | input | 1 | Write display status |
| ddat_wr_i | input | 1 | Write display data |
| rd_data_o | output | 16 | CPU read data, same cycle as strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
The checker watches every cycle that a taken keyboard character drops `kb_ready_o`, that a full keyboard stays closed until its data is read, that a data read reopens it, that a display write presents its character and that a done pulse ends it, and that the interrupt line matches the flag and enable bits. The zero fields of the read words are checked whenever a status is read. Only the bench scenarios show that a refused character leaves the held one intact, that a same-cycle arrival and read is resolved in the stated order, that a status write leaves bit 15 alone, and that a done pulse on an idle display changes nothing.

// File: rtl/kd_pkg.sv
// Package: shared constants for the keyboard/display register block.
// Assumes status words put the ready flag in the top bit and the
// interrupt enable in the bit below it.
package kd_pkg;
    localparam int KD_CHAR_W = 8;
    localparam int KD_REG_W  = 16;

    // Read source selected by the one-hot read strobes.
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_KSTS = 2'd1,
        RSEL_KDAT = 2'd2,
        RSEL_DSTS = 2'd3
    } rsel_t;
endpackage

// File: rtl/kd_kbd_chan.sv
// Keyboard channel: holds one character and the keyboard ready flag and
// interrupt enable. Assumes the keyboard holds its character while
// ready_o is low. A data read clears the flag; a taken character sets it.
module kd_kbd_chan #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] char_i,
    input  logic              valid_i,
    input  logic              data_rd_i,
    input  logic              ie_wr_i,
    input  logic              ie_val_i,
    output logic              ready_o,
    output logic              full_o,
    output logic              ie_o,
    output logic [CHAR_W-1:0] data_o
);
    logic              full_q;
    logic              ie_q;
    logic [CHAR_W-1:0] data_q;
    logic              take;

    // Purpose: a character is taken only while the holding register is empty.
    always_comb take = valid_i && !full_q;

    // Purpose: ready flag and held character, set by arrival, cleared by read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take) begin
            full_q <= 1'b1;
            data_q <= char_i;
        end else if (data_rd_i) begin
            full_q <= 1'b0;
        end
    end

    // Purpose: interrupt enable, loaded only by a status write.
    always_ff @(posedge clk) begin
        if (!rst_n) ie_q <= 1'b0;
        else if (ie_wr_i) ie_q <= ie_val_i;
    end

    assign ready_o = !full_q;
    assign full_o  = full_q;
    assign ie_o    = ie_q;
    assign data_o  = data_q;
endmodule

// File: rtl/kd_disp_chan.sv
// Display channel: holds the character being shown and the display ready
// flag and interrupt enable. Assumes done_i pulses once per character.
// A data write clears the flag; done sets it; write wins over done.
module kd_disp_chan #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr_i,
    input  logic [CHAR_W-1:0] wchar_i,
    input  logic              done_i,
    input  logic              ie_wr_i,
    input  logic              ie_val_i,
    output logic [CHAR_W-1:0] char_o,
    output logic              valid_o,
    output logic              rdy_o,
    output logic              ie_o
);
    logic              rdy_q;
    logic              ie_q;
    logic [CHAR_W-1:0] char_q;

    // Purpose: ready flag and output character driven by write and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q  <= 1'b1;
            char_q <= '0;
        end else if (data_wr_i) begin
            rdy_q  <= 1'b0;
            char_q <= wchar_i;
        end else if (done_i && !rdy_q) begin
            rdy_q  <= 1'b1;
        end
    end

    // Purpose: interrupt enable, loaded only by a status write.
    always_ff @(posedge clk) begin
        if (!rst_n) ie_q <= 1'b0;
        else if (ie_wr_i) ie_q <= ie_val_i;
    end

    assign char_o  = char_q;
    assign valid_o = !rdy_q;
    assign rdy_o   = rdy_q;
    assign ie_o    = ie_q;
endmodule

// File: rtl/kd_rdmux.sv
// Read path and interrupt combine: builds the status words, selects the
// read word from the one-hot strobes and forms the interrupt request.
// Assumes at most one read strobe per cycle.
module kd_rdmux
    import kd_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int REG_W  = 16
) (
    input  logic              ksts_rd_i,
    input  logic              kdat_rd_i,
    input  logic              dsts_rd_i,
    input  logic              kb_full_i,
    input  logic              kb_ie_i,
    input  logic [CHAR_W-1:0] kb_data_i,
    input  logic              dp_rdy_i,
    input  logic              dp_ie_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              irq_o
);
    localparam int RDY_BIT = REG_W - 1;
    localparam int IE_BIT  = REG_W - 2;

    logic [REG_W-1:0] ksts_w;
    logic [REG_W-1:0] dsts_w;
    logic [REG_W-1:0] kdat_w;
    rsel_t            sel;

    // Purpose: assemble status and data words with zeroed unused fields.
    always_comb begin
        ksts_w          = '0;
        ksts_w[RDY_BIT] = kb_full_i;
        ksts_w[IE_BIT]  = kb_ie_i;
        dsts_w          = '0;
        dsts_w[RDY_BIT] = dp_rdy_i;
        dsts_w[IE_BIT]  = dp_ie_i;
        kdat_w          = '0;
        kdat_w[CHAR_W-1:0] = kb_data_i;
    end

    // Purpose: encode the read strobes into a source select.
    always_comb begin
        if (ksts_rd_i)      sel = RSEL_KSTS;
        else if (kdat_rd_i) sel = RSEL_KDAT;
        else if (dsts_rd_i) sel = RSEL_DSTS;
        else                sel = RSEL_NONE;
    end

    // Purpose: drive the read word for the selected source.
    always_comb begin
        case (sel)
            RSEL_KSTS: rd_data_o = ksts_w;
            RSEL_KDAT: rd_data_o = kdat_w;
            RSEL_DSTS: rd_data_o = dsts_w;
            default:   rd_data_o = '0;
        endcase
    end

    // Purpose: interrupt when either channel is ready with its enable set.
    always_comb irq_o = (kb_full_i && kb_ie_i) || (dp_rdy_i && dp_ie_i);
endmodule

// File: rtl/kd_regs.sv
// Top: keyboard and display device registers behind per-register strobes
// from an external decoder. Assumes one read strobe at a time; the read
// word is combinational in the strobe's cycle.
module kd_regs #(
    parameter int CHAR_W = kd_pkg::KD_CHAR_W,
    parameter int REG_W  = kd_pkg::KD_REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] kb_char_i,
    input  logic              kb_valid_i,
    output logic              kb_ready_o,
    output logic [CHAR_W-1:0] dp_char_o,
    output logic              dp_valid_o,
    input  logic              dp_done_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic              ksts_rd_i,
    input  logic              ksts_wr_i,
    input  logic              kdat_rd_i,
    input  logic              dsts_rd_i,
    input  logic              dsts_wr_i,
    input  logic              ddat_wr_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              irq_o
);
    localparam int IE_BIT = REG_W - 2;

    logic              kb_full;
    logic              kb_ie;
    logic [CHAR_W-1:0] kb_data;
    logic              dp_rdy;
    logic              dp_ie;

    kd_kbd_chan #(.CHAR_W(CHAR_W)) u_kbd (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_i    (kb_char_i),
        .valid_i   (kb_valid_i),
        .data_rd_i (kdat_rd_i),
        .ie_wr_i   (ksts_wr_i),
        .ie_val_i  (wr_data_i[IE_BIT]),
        .ready_o   (kb_ready_o),
        .full_o    (kb_full),
        .ie_o      (kb_ie),
        .data_o    (kb_data)
    );

    kd_disp_chan #(.CHAR_W(CHAR_W)) u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr_i (ddat_wr_i),
        .wchar_i   (wr_data_i[CHAR_W-1:0]),
        .done_i    (dp_done_i),
        .ie_wr_i   (dsts_wr_i),
        .ie_val_i  (wr_data_i[IE_BIT]),
        .char_o    (dp_char_o),
        .valid_o   (dp_valid_o),
        .rdy_o     (dp_rdy),
        .ie_o      (dp_ie)
    );

    kd_rdmux #(.CHAR_W(CHAR_W), .REG_W(REG_W)) u_rd (
        .ksts_rd_i (ksts_rd_i),
        .kdat_rd_i (kdat_rd_i),
        .dsts_rd_i (dsts_rd_i),
        .kb_full_i (kb_full),
        .kb_ie_i   (kb_ie),
        .kb_data_i (kb_data),
        .dp_rdy_i  (dp_rdy),
        .dp_ie_i   (dp_ie),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/kd_regs_chk.sv
// Checker for kd_regs: cycle-by-cycle properties over the ports and the
// channel state signals. Attached by the bind at the end of this file.
module kd_regs_chk #(
    parameter int CHAR_W = 8,
    parameter int REG_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              kb_valid_i,
    input logic              kb_ready_o,
    input logic [CHAR_W-1:0] dp_char_o,
    input logic              dp_valid_o,
    input logic              dp_done_i,
    input logic [REG_W-1:0]  wr_data_i,
    input logic              ksts_rd_i,
    input logic              kdat_rd_i,
    input logic              dsts_rd_i,
    input logic              ddat_wr_i,
    input logic [REG_W-1:0]  rd_data_o,
    input logic              irq_o,
    input logic              kb_full,
    input logic              kb_ie,
    input logic              dp_rdy,
    input logic              dp_ie
);
    assert_take_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        kb_valid_i && kb_ready_o |=> !kb_ready_o);

    assert_full_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !kb_ready_o && !kdat_rd_i |=> !kb_ready_o);

    assert_read_reopens_R4: assert property (@(posedge clk) disable iff (!rst_n)
        kdat_rd_i && !kb_ready_o |=> kb_ready_o);

    assert_dwrite_shows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ddat_wr_i |=> dp_valid_o && (dp_char_o == $past(wr_data_i[CHAR_W-1:0])));

    assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dp_done_i && dp_valid_o && !ddat_wr_i |=> !dp_valid_o);

    assert_irq_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == ((kb_full && kb_ie) || (dp_rdy && dp_ie)));

    assert_sts_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ksts_rd_i || dsts_rd_i) |-> (rd_data_o[REG_W-3:0] == '0));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ksts_rd_i || kdat_rd_i || dsts_rd_i) |-> (rd_data_o == '0));
endmodule

bind kd_regs kd_regs_chk #(.CHAR_W(CHAR_W), .REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .kb_valid_i (kb_valid_i),
    .kb_ready_o (kb_ready_o),
    .dp_char_o  (dp_char_o),
    .dp_valid_o (dp_valid_o),
    .dp_done_i  (dp_done_i),
    .wr_data_i  (wr_data_i),
    .ksts_rd_i  (ksts_rd_i),
    .kdat_rd_i  (kdat_rd_i),
    .dsts_rd_i  (dsts_rd_i),
    .ddat_wr_i  (ddat_wr_i),
    .rd_data_o  (rd_data_o),
    .irq_o      (irq_o),
    .kb_full    (kb_full),
    .kb_ie      (kb_ie),
    .dp_rdy     (dp_rdy),
    .dp_ie      (dp_ie)
);

// File: tb/tb_kd_regs.sv
// Directed bench for kd_regs: one task per scenario, inputs driven on the
// falling edge, outputs sampled 1 ns later.
module tb_kd_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  kb_char_i = '0;
    logic        kb_valid_i = 1'b0;
    logic        kb_ready_o;
    logic [7:0]  dp_char_o;
    logic        dp_valid_o;
    logic        dp_done_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic        ksts_rd_i = 1'b0, ksts_wr_i = 1'b0, kdat_rd_i = 1'b0;
    logic        dsts_rd_i = 1'b0, dsts_wr_i = 1'b0, ddat_wr_i = 1'b0;
    logic [15:0] rd_data_o;
    logic        irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    kd_regs dut (
        .clk(clk), .rst_n(rst_n),
        .kb_char_i(kb_char_i), .kb_valid_i(kb_valid_i), .kb_ready_o(kb_ready_o),
        .dp_char_o(dp_char_o), .dp_valid_o(dp_valid_o), .dp_done_i(dp_done_i),
        .wr_data_i(wr_data_i),
        .ksts_rd_i(ksts_rd_i), .ksts_wr_i(ksts_wr_i), .kdat_rd_i(kdat_rd_i),
        .dsts_rd_i(dsts_rd_i), .dsts_wr_i(dsts_wr_i), .ddat_wr_i(ddat_wr_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
        end
    endtask

    // which: 0 keyboard status, 1 keyboard data, 2 display status
    task automatic cpu_rd(input int which, output logic [15:0] v);
        @(negedge clk);
        ksts_rd_i = (which == 0);
        kdat_rd_i = (which == 1);
        dsts_rd_i = (which == 2);
        #1 v = rd_data_o;
        @(negedge clk);
        ksts_rd_i = 0; kdat_rd_i = 0; dsts_rd_i = 0;
    endtask

    // which: 0 keyboard status, 1 display status, 2 display data
    task automatic cpu_wr(input int which, input logic [15:0] d);
        @(negedge clk);
        wr_data_i = d;
        ksts_wr_i = (which == 0);
        dsts_wr_i = (which == 1);
        ddat_wr_i = (which == 2);
        @(negedge clk);
        ksts_wr_i = 0; dsts_wr_i = 0; ddat_wr_i = 0;
    endtask

    task automatic key_offer(input logic [7:0] c);
        @(negedge clk);
        kb_char_i = c; kb_valid_i = 1;
        @(negedge clk);
        kb_valid_i = 0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        #1;
        check("R1", "kb_ready", 16'(kb_ready_o), 16'h1);
        check("R1", "dp_valid", 16'(dp_valid_o), 16'h0);
        check("R1", "irq", 16'(irq_o), 16'h0);
        cpu_rd(0, v); check("R1", "kbd status", v, 16'h0000);
        cpu_rd(2, v); check("R1", "disp status", v, 16'h8000);
    endtask

    task automatic t_key_basic;
        logic [15:0] v;
        key_offer(8'h41);
        #1 check("R2", "kb_ready after take", 16'(kb_ready_o), 16'h0);
        cpu_rd(0, v); check("R2", "kbd status full", v, 16'h8000);
        cpu_rd(1, v); check("R4", "kbd data", v, 16'h0041);
        #1 check("R4", "kb_ready after read", 16'(kb_ready_o), 16'h1);
        cpu_rd(0, v); check("R4", "kbd status cleared", v, 16'h0000);
    endtask

    task automatic t_key_refuse;
        logic [15:0] v;
        key_offer(8'h11);
        key_offer(8'h22);
        #1 check("R3", "kb_ready still low", 16'(kb_ready_o), 16'h0);
        cpu_rd(1, v); check("R3", "held char kept", v, 16'h0011);
    endtask

    task automatic t_key_same_cycle;
        logic [15:0] v;
        key_offer(8'h33);
        @(negedge clk);
        kb_char_i = 8'h44; kb_valid_i = 1; kdat_rd_i = 1;
        #1 v = rd_data_o;
        check("R5", "read in collision cycle", v, 16'h0033);
        check("R5", "no take in collision cycle", 16'(kb_ready_o), 16'h0);
        @(negedge clk);
        kdat_rd_i = 0;
        #1 check("R5", "open cycle after read", 16'(kb_ready_o), 16'h1);
        @(negedge clk);
        kb_valid_i = 0;
        #1 check("R5", "taken next cycle", 16'(kb_ready_o), 16'h0);
        cpu_rd(1, v); check("R5", "second char", v, 16'h0044);
    endtask

    task automatic t_display;
        logic [15:0] v;
        cpu_wr(2, 16'hAB58);
        #1 check("R6", "dp_valid", 16'(dp_valid_o), 16'h1);
        check("R6", "dp_char", 16'(dp_char_o), 16'h0058);
        cpu_rd(2, v); check("R6", "disp status busy", v, 16'h0000);
        @(negedge clk); dp_done_i = 1;
        @(negedge clk); dp_done_i = 0;
        #1 check("R7", "dp_valid after done", 16'(dp_valid_o), 16'h0);
        cpu_rd(2, v); check("R7", "disp status ready", v, 16'h8000);
        @(negedge clk); dp_done_i = 1;
        @(negedge clk); dp_done_i = 0;
        cpu_rd(2, v); check("R7", "idle done ignored", v, 16'h8000);
        check("R7", "idle done dp_valid", 16'(dp_valid_o), 16'h0);
    endtask

    task automatic t_status_irq;
        logic [15:0] v;
        cpu_wr(0, 16'hFFFF);
        cpu_rd(0, v); check("R8", "kbd status write only bit 14", v, 16'h4000);
        check("R9", "irq kbd enabled not ready", 16'(irq_o), 16'h0);
        cpu_wr(1, 16'h4000);
        cpu_rd(2, v); check("R8", "disp status enable", v, 16'hC000);
        check("R9", "irq display", 16'(irq_o), 16'h1);
        cpu_wr(1, 16'h0000);
        cpu_rd(2, v); check("R8", "disp status keeps ready", v, 16'h8000);
        check("R9", "irq display off", 16'(irq_o), 16'h0);
        key_offer(8'h5A);
        #1 check("R9", "irq keyboard", 16'(irq_o), 16'h1);
        cpu_wr(0, 16'h3FFF);
        cpu_rd(0, v); check("R8", "kbd ready kept on write", v, 16'h8000);
        check("R9", "irq keyboard disabled", 16'(irq_o), 16'h0);
        cpu_rd(1, v); check("R10", "kbd data upper zero", v, 16'h005A);
    endtask

    task automatic t_idle_read;
        @(negedge clk);
        #1 check("R10", "no strobe read", rd_data_o, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_key_basic;
        t_key_refuse;
        t_key_same_cycle;
        t_display;
        t_status_irq;
        t_idle_read;
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule